// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns characters into an asynchronous serial frame on one output line. The frame shape is chosen at run time from a set of configuration inputs: data length, parity kind, stop length, bit order and the number of baud ticks per bit. A free-running divisor on the system clock produces the baud ticks. A single-entry holding register accepts one character while the previous one is being shifted out, so consecutive characters leave without a gap.

Software controls the transmitter with one-cycle command pulses. These enable it, disable it, reset it, start and stop a break, and mark the next character as an address in multidrop operation. Two status outputs report whether a new character can be written and whether everything has drained.

Top module: `atx_serializer`

## Requirements
- R1: After rst_n is released, tx is 1, tx_ready is 1, tx_empty is 1, and the transmitter is disabled: a written character is held and not sent until an enable pulse arrives.
- R2: A frame is a 0 start bit, then the data bits, then an optional parity bit, then stop time at 1. The number of data bits is 5, 6, 7 or 8 for cfg_len codes 0, 1, 2 and 3. When cfg_nine is 1, the frame carries 9 bits (wr_data[8:0]) whatever cfg_len holds.
- R3: With cfg_msb at 0, wr_data bit 0 is sent first. With cfg_msb at 1, the highest used data bit is sent first.
- R4: cfg_par codes: 0 gives even parity (the data plus the parity bit hold an even number of ones), 1 gives odd parity, 2 forces a 0, 3 forces a 1, 4 and 5 send no parity bit, and 6 and 7 select multidrop.
- R5: In multidrop mode the parity slot is 1 for the first character loaded after a cmd_addr pulse and 0 for every other character.
- R6: cfg_stop code 0 gives 1 bit period of stop time. Code 1 gives 1.5 periods (24 ticks at 16x, 12 at 8x). Codes 2 and 3 give 2 periods.
- R7: A bit lasts 16 baud ticks when cfg_over8 is 0 and 8 ticks when it is 1. A tick occurs every `divisor` clocks. When characters follow each other through the holding register, the falling start edges are exactly (frame ticks × divisor) clocks apart.
- R8: With divisor 0 no ticks are produced. tx stays 1, and a held character waits (tx_ready 0) until a non-zero divisor is applied.
- R9: cmd_en and cmd_dis are one-shot pulses, and cmd_dis wins when both arrive together. A frame already on the line completes. While disabled, a held character is not sent. After a later enable, that held character is sent.
- R10: cmd_rst aborts the frame in progress. From the next cycle tx is 1, tx_ready is 1 and tx_empty is 1. It also clears a pending address mark and any break request.
- R11: cmd_brk_on drives tx to 0, starting exactly when the frame in progress ends. tx stays 0 with tx_empty at 0 until cmd_brk_off, which returns tx to 1 on the next cycle.
- R12: tx_ready is 1 exactly when the holding register is empty. A write while it is full is ignored. tx_empty is 1 only when both the holding register and the shifter are idle, and then tx is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_nine | input | 1 | 9-bit data override |
| cfg_par | input | 3 | Parity kind code |
| cfg_stop | input | 2 | Stop length code |
| cfg_msb | input | 1 | Send most significant bit first |
| cfg_over8 | input | 1 | 8 ticks per bit when 1, 16 when 0 |
| divisor | input | DIV_W | Clocks per baud tick; 0 stops ticks |
| cmd_en | input | 1 | Enable pulse |
| cmd_dis | input | 1 | Disable pulse |
| cmd_rst | input | 1 | Reset transmitter pulse |
| cmd_brk_on | input | 1 | Start break pulse |
| cmd_brk_off | input | 1 | Stop break pulse |
| cmd_addr | input | 1 | Mark next character as address |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Character to send |
| tx | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter idle |

## Verification
The bench builds the block with its default DIV_W of 16. Most runs use a divisor of 1, so one tick arrives every clock and the bench can predict each bit centre and each frame length to the exact cycle. With that setting it sweeps every data length, every parity code and both bit orders, then every stop code at both oversampling ratios. Two further runs cover timing and stalling: a divisor of 3 checks that the frame-to-frame spacing scales with the divisor, and a divisor of 0 checks that transmission stalls.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int DATA_W = 9;
    localparam int NB_W   = 4;
    localparam int CNT_W  = 6;
    localparam int OS_HI  = 16;
    localparam int OS_LO  = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_BRK   = 3'd5
    } atx_state_e;

    typedef struct packed {
        atx_state_e         st;
        logic [CNT_W-1:0]   tcnt;
        logic [NB_W-1:0]    bidx;
        logic [DATA_W-1:0]  sr;
        logic               par_bit;
        logic               par_en;
        logic [NB_W-1:0]    nbits;
        logic [CNT_W-1:0]   bit_len;
        logic [CNT_W-1:0]   stop_len;
        logic [DATA_W-1:0]  hold;
        logic               hold_full;
        logic               en;
        logic               brk;
        logic               addr_pend;
    } atx_regs_t;
endpackage

// File: rtl/atx_baud.sv
module atx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             run;

    always_comb begin
        run   = (divisor != '0);
        tick  = run && (cnt_q >= divisor - 1'b1);
        cnt_d = (!run || tick || restart) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/atx_frame.sv
module atx_frame
    import atx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_sel,
    input  logic              nine,
    input  logic [2:0]        par_sel,
    input  logic              msb_first,
    input  logic              addr_flag,
    output logic [DATA_W-1:0] bits,
    output logic [NB_W-1:0]   nbits,
    output logic              par_en,
    output logic              par_bit
);
    logic            ones;
    logic [NB_W-1:0] j;

    always_comb begin
        nbits = nine ? NB_W'(DATA_W) : NB_W'(5) + NB_W'(len_sel);
        ones  = 1'b0;
        bits  = '0;
        j     = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (NB_W'(i) < nbits) begin
                ones    = ones ^ data[i];
                j       = nbits - 1'b1 - NB_W'(i);
                bits[i] = msb_first ? data[j] : data[i];
            end
        end
        par_en = 1'b1;
        unique case (par_sel)
            3'd0:        par_bit = ones;
            3'd1:        par_bit = ~ones;
            3'd2:        par_bit = 1'b0;
            3'd3:        par_bit = 1'b1;
            3'd4, 3'd5:  begin par_bit = 1'b0; par_en = 1'b0; end
            default:     par_bit = addr_flag;
        endcase
    end
endmodule

// File: rtl/atx_serializer.sv
module atx_serializer
    import atx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_nine,
    input  logic [2:0]       cfg_par,
    input  logic [1:0]       cfg_stop,
    input  logic             cfg_msb,
    input  logic             cfg_over8,
    input  logic [DIV_W-1:0] divisor,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             cmd_rst,
    input  logic             cmd_brk_on,
    input  logic             cmd_brk_off,
    input  logic             cmd_addr,
    input  logic             wr_valid,
    input  logic [8:0]       wr_data,
    output logic             tx,
    output logic             tx_ready,
    output logic             tx_empty
);
    atx_regs_t         r_d, r_q;
    logic              tick, restart, do_load, can_load, busy, last_tick;
    logic [CNT_W-1:0]  cur_len, os_len, stp_len;
    logic [DATA_W-1:0] f_bits;
    logic [NB_W-1:0]   f_nbits;
    logic              f_par_en, f_par_bit;

    atx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor),
        .restart(restart), .tick(tick)
    );

    atx_frame u_frame (
        .data(r_q.hold), .len_sel(cfg_len), .nine(cfg_nine),
        .par_sel(cfg_par), .msb_first(cfg_msb), .addr_flag(r_q.addr_pend),
        .bits(f_bits), .nbits(f_nbits), .par_en(f_par_en), .par_bit(f_par_bit)
    );

    always_comb begin
        os_len = cfg_over8 ? CNT_W'(OS_LO) : CNT_W'(OS_HI);
        unique case (cfg_stop)
            2'd0:    stp_len = os_len;
            2'd1:    stp_len = os_len + (os_len >> 1);
            default: stp_len = os_len << 1;
        endcase
    end

    always_comb begin
        r_d       = r_q;
        restart   = 1'b0;
        do_load   = 1'b0;
        busy      = (r_q.st != ST_IDLE) && (r_q.st != ST_BRK);
        can_load  = r_q.en && r_q.hold_full && !r_q.brk && (divisor != '0);
        cur_len   = (r_q.st == ST_STOP) ? r_q.stop_len : r_q.bit_len;
        last_tick = tick && (r_q.tcnt == cur_len - 1'b1);

        if (cmd_en)      r_d.en = 1'b1;
        if (cmd_dis)     r_d.en = 1'b0;
        if (cmd_brk_on)  r_d.brk = 1'b1;
        if (cmd_brk_off) r_d.brk = 1'b0;
        if (cmd_addr)    r_d.addr_pend = 1'b1;
        if (wr_valid && !r_q.hold_full) begin
            r_d.hold      = wr_data;
            r_d.hold_full = 1'b1;
        end

        if (busy && tick) r_d.tcnt = last_tick ? '0 : r_q.tcnt + 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.brk) r_d.st = ST_BRK;
                else if (can_load) begin
                    do_load = 1'b1;
                    restart = 1'b1;
                end
            end
            ST_START: if (last_tick) begin
                r_d.st   = ST_DATA;
                r_d.bidx = '0;
            end
            ST_DATA: if (last_tick) begin
                r_d.sr = r_q.sr >> 1;
                if (r_q.bidx == r_q.nbits - 1'b1)
                    r_d.st = r_q.par_en ? ST_PAR : ST_STOP;
                else
                    r_d.bidx = r_q.bidx + 1'b1;
            end
            ST_PAR: if (last_tick) r_d.st = ST_STOP;
            ST_STOP: if (last_tick) begin
                if (r_q.brk)       r_d.st = ST_BRK;
                else if (can_load) do_load = 1'b1;
                else               r_d.st = ST_IDLE;
            end
            ST_BRK: if (!r_d.brk) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase

        if (do_load) begin
            r_d.st        = ST_START;
            r_d.tcnt      = '0;
            r_d.sr        = f_bits;
            r_d.nbits     = f_nbits;
            r_d.par_en    = f_par_en;
            r_d.par_bit   = f_par_bit;
            r_d.bit_len   = os_len;
            r_d.stop_len  = stp_len;
            r_d.hold_full = 1'b0;
            r_d.addr_pend = 1'b0;
        end

        if (cmd_rst) begin
            r_d.st        = ST_IDLE;
            r_d.tcnt      = '0;
            r_d.hold_full = 1'b0;
            r_d.addr_pend = 1'b0;
            r_d.brk       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (r_q.st)
            ST_START, ST_BRK: tx = 1'b0;
            ST_DATA:          tx = r_q.sr[0];
            ST_PAR:           tx = r_q.par_bit;
            default:          tx = 1'b1;
        endcase
        tx_ready = !r_q.hold_full;
        tx_empty = !r_q.hold_full && (r_q.st == ST_IDLE);
    end

    // R12
    empty_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx);

    // R12
    full_hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hold_full && !cmd_rst) |=> (r_q.hold == $past(r_q.hold)));

    // R10
    rst_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> (tx && tx_ready && tx_empty));

    // R8
    zero_div_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && divisor == '0) |=> (r_q.st != ST_START));

    // R9
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !r_q.en) |=> (r_q.st != ST_START));

    // R11
    brk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_brk_off && r_q.st == ST_BRK) |=> (r_q.st != ST_BRK));

    // R7
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.tcnt < cur_len));
endmodule

// File: tb/atx_serializer_tb.sv
module atx_serializer_tb;
    localparam int C_EN = 0, C_DIS = 1, C_RST = 2, C_BON = 3, C_BOFF = 4, C_ADDR = 5;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  cfg_len = 2'd3, cfg_stop = 2'd0;
    logic        cfg_nine = 1'b0, cfg_msb = 1'b0, cfg_over8 = 1'b0;
    logic [2:0]  cfg_par = 3'd4;
    logic [15:0] divisor = 16'd1;
    logic        cmd_en = 0, cmd_dis = 0, cmd_rst = 0, cmd_brk_on = 0, cmd_brk_off = 0, cmd_addr = 0;
    logic        wr_valid = 0;
    logic [8:0]  wr_data = '0;
    logic        tx, tx_ready, tx_empty;
    int          n_chk = 0, n_fail = 0;
    longint      cyc = 0;
    bit          done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    atx_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_nine(cfg_nine),
        .cfg_par(cfg_par), .cfg_stop(cfg_stop), .cfg_msb(cfg_msb),
        .cfg_over8(cfg_over8), .divisor(divisor), .cmd_en(cmd_en),
        .cmd_dis(cmd_dis), .cmd_rst(cmd_rst), .cmd_brk_on(cmd_brk_on),
        .cmd_brk_off(cmd_brk_off), .cmd_addr(cmd_addr), .wr_valid(wr_valid),
        .wr_data(wr_data), .tx(tx), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            C_EN:    cmd_en = 1;
            C_DIS:   cmd_dis = 1;
            C_RST:   cmd_rst = 1;
            C_BON:   cmd_brk_on = 1;
            C_BOFF:  cmd_brk_off = 1;
            default: cmd_addr = 1;
        endcase
        @(negedge clk);
        {cmd_en, cmd_dis, cmd_rst, cmd_brk_on, cmd_brk_off, cmd_addr} = '0;
    endtask

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        wr_valid = 1; wr_data = d;
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic watch(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx == 1'b0) lows++;
        end
    endtask

    task automatic capture(input int nb, input int os, input int dv,
                           output logic [12:0] bits, output longint fall);
        int guard = 0;
        bits = '0;
        while (tx !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
        fall = cyc;
        repeat (os * dv / 2) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            bits[k] = tx;
            if (k < nb - 1) repeat (os * dv) @(negedge clk);
        end
    endtask

    function automatic logic [12:0] expf(input logic [8:0] d, input int n, input bit msb,
                                         input int pc, input bit adr);
        logic [12:0] f = '0;
        int ones = 0;
        int hp = (pc == 4 || pc == 5) ? 0 : 1;
        for (int i = 0; i < n; i++) begin
            f[1+i] = msb ? d[n-1-i] : d[i];
            ones += d[i];
        end
        if (hp == 1) begin
            case (pc)
                0: f[1+n] = ones[0];
                1: f[1+n] = ~ones[0];
                2: f[1+n] = 1'b0;
                3: f[1+n] = 1'b1;
                default: f[1+n] = adr;
            endcase
        end
        f[1+n+hp] = 1'b1;
        return f;
    endfunction

    task automatic wait_empty();
        int guard = 0;
        while (!tx_empty && guard < 2000) begin @(negedge clk); guard++; end
    endtask

    task automatic set_cfg(input int lc, input int pc, input int sc, input int m, input int ov, input int dv);
        @(negedge clk);
        cfg_nine = (lc == 4); cfg_len = (lc == 4) ? 2'd3 : lc[1:0];
        cfg_par = pc[2:0]; cfg_stop = sc[1:0]; cfg_msb = m[0]; cfg_over8 = ov[0];
        divisor = dv[15:0];
    endtask

    // R2 R3 R4 R5 R6 R7: two back-to-back characters in one configuration
    task automatic run_pair(input int lc, input int pc, input int sc, input int m,
                            input int ov, input int dv, input logic [8:0] a, input logic [8:0] b);
        logic [12:0] ga, gb, ea, eb;
        longint fa, fb;
        int n, hp, nb, os, stt, tt;
        set_cfg(lc, pc, sc, m, ov, dv);
        n = (lc == 4) ? 9 : 5 + lc;
        hp = (pc == 4 || pc == 5) ? 0 : 1;
        nb = n + hp + 2;
        os = ov ? 8 : 16;
        stt = (sc == 0) ? os : (sc == 1) ? os + os / 2 : 2 * os;
        tt = (1 + n + hp) * os + stt;
        if (pc >= 6) pulse(C_ADDR);
        ea = expf(a, n, m[0], pc, 1'b1);
        eb = expf(b, n, m[0], pc, 1'b0);
        fork
            begin
                capture(nb, os, dv, ga, fa);
                capture(nb, os, dv, gb, fb);
            end
            begin
                int g = 0;
                wr(a);
                while (!tx_ready && g < 100) begin @(negedge clk); g++; end
                wr(b);
            end
        join
        chk(ga == ea, "R2 R3 R4 R5 first frame bits", ga, ea);
        chk(gb == eb, "R2 R3 R4 R5 second frame bits", gb, eb);
        chk((fb - fa) == longint'(tt * dv), "R6 R7 frame spacing", fb - fa, tt * dv);
        wait_empty();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lows;
        logic [12:0] g, e;
        longint f0, f1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(tx == 1 && tx_ready == 1 && tx_empty == 1, "R1 reset outputs",
            {tx, tx_ready, tx_empty}, 3'b111);

        // R1 R9: disabled after reset, character held
        wr(9'h0A5);
        watch(60, lows);
        chk(lows == 0, "R1 R9 disabled holds line high", lows, 0);
        chk(tx_ready == 0, "R12 ready low while held", tx_ready, 0);
        wr(9'h03C);   // R12: ignored, holding register full
        pulse(C_EN);
        capture(10, 16, 1, g, f0);
        e = expf(9'h0A5, 8, 0, 4, 0);
        chk(g == e, "R9 R12 held character sent after enable", g, e);
        wait_empty();
        watch(300, lows);
        chk(lows == 0, "R12 write while full ignored", lows, 0);
        chk(tx_empty == 1, "R12 empty after drain", tx_empty, 1);

        // Main sweep: lengths x parity codes x bit order
        for (int lc = 0; lc < 5; lc++)
            for (int pc = 0; pc < 8; pc++)
                for (int m = 0; m < 2; m++) begin
                    int k = lc * 16 + pc * 2 + m;
                    logic [8:0] a = 9'((k * 73 + 29) & 9'h1FF);
                    run_pair(lc, pc, 0, m, (lc + pc) % 2, 1, a, ~a);
                end

        // R6 stop codes at both oversampling ratios
        for (int sc = 0; sc < 4; sc++)
            for (int ov = 0; ov < 2; ov++)
                run_pair(3, 1, sc, 0, ov, 1, 9'(8'h5A + sc * 7 + ov), 9'h0C3);

        // R7 divisor scaling
        run_pair(3, 4, 0, 0, 1, 3, 9'h017, 9'h0E8);

        // R8 zero divisor stalls
        set_cfg(3, 4, 0, 0, 0, 0);
        wr(9'h066);
        watch(100, lows);
        chk(lows == 0, "R8 zero divisor keeps line high", lows, 0);
        chk(tx_ready == 0, "R8 character waits", tx_ready, 0);
        @(negedge clk); divisor = 16'd1;
        capture(10, 16, 1, g, f0);
        e = expf(9'h066, 8, 0, 4, 0);
        chk(g == e, "R8 sent after divisor set", g, e);
        wait_empty();

        // R9 disable mid-frame: frame completes, next one held
        fork
            capture(10, 16, 1, g, f0);
            begin
                wr(9'h0B1);
                repeat (30) @(negedge clk);
                pulse(C_DIS);
                wr(9'h04E);
            end
        join
        e = expf(9'h0B1, 8, 0, 4, 0);
        chk(g == e, "R9 frame in progress completes", g, e);
        watch(300, lows);
        chk(lows == 0, "R9 held character not sent while disabled", lows, 0);
        chk(tx_ready == 0, "R9 character still held", tx_ready, 0);
        pulse(C_EN);
        capture(10, 16, 1, g, f0);
        e = expf(9'h04E, 8, 0, 4, 0);
        chk(g == e, "R9 resumes from holding register", g, e);
        wait_empty();

        // R10 reset aborts a frame
        wr(9'h000);
        begin
            int gd = 0;
            while (tx !== 1'b0 && gd < 100) begin @(negedge clk); gd++; end
        end
        repeat (40) @(negedge clk);
        pulse(C_RST);
        chk(tx == 1 && tx_ready == 1 && tx_empty == 1, "R10 reset command idles",
            {tx, tx_ready, tx_empty}, 3'b111);
        watch(200, lows);
        chk(lows == 0, "R10 aborted frame stays off", lows, 0);

        // R10 reset clears a pending address mark
        set_cfg(3, 6, 0, 0, 0, 1);
        pulse(C_ADDR);
        pulse(C_RST);
        fork
            capture(11, 16, 1, g, f0);
            wr(9'h081);
        join
        e = expf(9'h081, 8, 0, 6, 0);
        chk(g == e, "R10 R5 address mark cleared", g, e);
        wait_empty();

        // R11 break after current frame
        set_cfg(3, 4, 0, 0, 0, 1);
        fork
            capture(10, 16, 1, g, f0);
            begin
                int gd = 0;
                wr(9'h0FF);
                while (tx !== 1'b0 && gd < 100) begin @(negedge clk); gd++; end
                repeat (20) @(negedge clk);
                pulse(C_BON);
            end
        join
        e = expf(9'h0FF, 8, 0, 4, 0);
        chk(g == e, "R11 frame completes before break", g, e);
        begin
            int gd = 0;
            while (tx !== 1'b0 && gd < 100) begin @(negedge clk); gd++; end
        end
        f1 = cyc;
        chk((f1 - f0) == 160, "R11 break begins at frame end", f1 - f0, 160);
        watch(100, lows);
        chk(lows == 100, "R11 break holds line low", lows, 100);
        chk(tx_empty == 0 && tx_ready == 1, "R11 status during break",
            {tx_empty, tx_ready}, 2'b01);
        pulse(C_BOFF);
        chk(tx == 1 && tx_empty == 1, "R11 stop break idles line", {tx, tx_empty}, 2'b11);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule